// File: doc/BRIEF.md
# Audio Master-Clock Divider for an I2S Master

This block lives entirely in the audio master-clock domain. From that one clock it derives the serial bit clock and the left/right word clock that an I2S master converter drives onto the bus. It can also forward the master clock itself. Both derived clocks come from one free-running frame counter, so their edges stay locked to each other and to the master clock. No second source is involved at any point. A typical master clock is 24.576 MHz, which is 512 times a 48 kHz sample rate.

Two select inputs choose the configuration. The first picks the ratio of master clock to sample rate. The second picks how many bit clocks make up one stereo frame. The block samples both selects only at a frame boundary, so a change never produces a shortened pulse. Some combinations cannot be divided cleanly. For these the block raises an error flag and holds both derived clocks low until the selects become legal again.

Top module: `i2s_mclk_divider`

## Requirements
- R1: `ratio_sel` picks the frame length in master-clock cycles: 0 gives 64, 1 gives 128, 2 gives 256 and 3 gives 512. The word clock period equals that many master-clock cycles.
- R2: The word clock is low for the first half of each frame (left channel) and high for the second half (right channel), which gives a 50% duty cycle. Its falling edge marks the frame boundary.
- R3: `frame_sel` picks the bit clocks per frame: 0 gives 32 and 1 gives 64. The bit clock has that many rising edges per frame. Its high and low phases each last ratio/(2·bits) master-clock cycles.
- R4: Every word-clock transition occurs in the same master-clock cycle as a bit-clock falling edge.
- R5: The selects are applied only at a frame boundary. A change made in the middle of a frame leaves the rest of that frame unchanged.
- R6: A combination is illegal when the ratio is less than twice the bits per frame; with the default settings this is 64 with 64. While an illegal combination is active, `cfg_err_o` is 1, both derived clocks are 0, and the selects are re-read every cycle. Once they are legal, the flag clears in the next cycle and a new frame starts from its beginning.
- R7: Reset is synchronous and active high. While it is sampled high, both derived clocks are 0 and the selects are loaded. After release, the frame starts from its beginning.
- R8: With forwarding enabled (the default), `mclk_o` follows the master clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 2 | Master-clock-to-sample-rate ratio select |
| frame_sel | input | 1 | Bit clocks per frame select |
| mclk_o | output | 1 | Forwarded master clock |
| bclk_o | output | 1 | Bit clock |
| wclk_o | output | 1 | Left/right word clock |
| cfg_err_o | output | 1 | Active configuration is illegal |

## Verification
The assertions assume that reset is applied before the clock outputs are relied on. They also assume that the selects are quasi-static: they may change in any cycle, but they are sampled only on the master-clock edge. The stimulus meets both assumptions. It holds reset from time zero and changes the selects only on the inactive clock edge. It deliberately includes changes in the middle of a frame, an illegal combination and a reset asserted in the middle of a run. The per-cycle reference model therefore sees the same sampling points as the design.

// File: rtl/i2s_clkdiv_pkg.sv
package i2s_clkdiv_pkg;

   // width of a log2-encoded length (frame ratio or bits per frame)
   localparam int unsigned LG_W = 5;

   typedef logic [LG_W-1:0] lg_t;

   // active configuration, both fields log2-encoded
   typedef struct packed {
      lg_t rl;   // log2 of master clocks per frame
      lg_t bl;   // log2 of bit clocks per frame
   } clk_cfg_t;

   // legal when every bit half-period spans at least one master clock
   function automatic logic cfg_fits(input clk_cfg_t c);
      return c.rl > c.bl;
   endfunction

endpackage

// File: rtl/i2s_cfg_reg.sv
module i2s_cfg_reg
   import i2s_clkdiv_pkg::*;
#(
   parameter int unsigned RATIO_LG_MIN = 6,
   parameter int unsigned RATIO_OPTS   = 4,
   parameter int unsigned BPF_LG_MIN   = 5,
   parameter int unsigned BPF_OPTS     = 2,
   parameter int unsigned RATIO_SEL_W  = 2,
   parameter int unsigned BPF_SEL_W    = 1
) (
   input  logic                   clk,
   input  logic                   load,
   input  logic [RATIO_SEL_W-1:0] ratio_sel,
   input  logic [BPF_SEL_W-1:0]   frame_sel,
   output clk_cfg_t               cfg_d,
   output logic                   ok_d,
   output clk_cfg_t               cfg_q,
   output logic                   ok_q
);

   clk_cfg_t req;
   logic     in_range;

   always_comb begin
      req.rl   = LG_W'(RATIO_LG_MIN) + LG_W'(ratio_sel);
      req.bl   = LG_W'(BPF_LG_MIN) + LG_W'(frame_sel);
      in_range = ({1'b0, ratio_sel} < (RATIO_SEL_W+1)'(RATIO_OPTS)) &&
                 ({1'b0, frame_sel} < (BPF_SEL_W+1)'(BPF_OPTS));
      cfg_d    = load ? req : cfg_q;
      ok_d     = load ? (in_range && cfg_fits(req)) : ok_q;
   end

   // reset forces load, so these flops need no reset branch of their own
   always_ff @(posedge clk) begin
      cfg_q <= cfg_d;
      ok_q  <= ok_d;
   end

endmodule

// File: rtl/i2s_frame_ctr.sv
module i2s_frame_ctr
   import i2s_clkdiv_pkg::*;
#(
   parameter int unsigned CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  lg_t              rl,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_d,
   output logic             wrap
);

   logic [CNT_W-1:0] last;

   always_comb begin
      last = {CNT_W{1'b1}} >> (LG_W'(CNT_W) - rl);
      wrap = run && (cnt_q == last);
      if (rst || !run || wrap) cnt_d = '0;
      else                     cnt_d = cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      cnt_q <= cnt_d;
   end

endmodule

// File: rtl/i2s_edge_gen.sv
module i2s_edge_gen
   import i2s_clkdiv_pkg::*;
#(
   parameter int unsigned CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cnt_d,
   input  clk_cfg_t         cfg_d,
   input  logic             ok_d,
   output logic             bclk_q,
   output logic             wclk_q,
   output logic             err_q
);

   lg_t              half_lg;
   logic [CNT_W-1:0] b_sh;
   logic [CNT_W-1:0] w_sh;

   always_comb begin
      half_lg = cfg_d.rl - cfg_d.bl - LG_W'(1);
      b_sh    = cnt_d >> half_lg;
      w_sh    = cnt_d >> (cfg_d.rl - LG_W'(1));
   end

   // outputs registered from the next count so they leave on a clean edge
   always_ff @(posedge clk) begin
      err_q <= !ok_d;
      if (rst) begin
         bclk_q <= 1'b0;
         wclk_q <= 1'b0;
      end else begin
         bclk_q <= ok_d & b_sh[0];
         wclk_q <= ok_d & w_sh[0];
      end
   end

endmodule

// File: rtl/i2s_mclk_divider.sv
module i2s_mclk_divider
   import i2s_clkdiv_pkg::*;
#(
   parameter int unsigned RATIO_LG_MIN = 6,
   parameter int unsigned RATIO_OPTS   = 4,
   parameter int unsigned BPF_LG_MIN   = 5,
   parameter int unsigned BPF_OPTS     = 2,
   parameter bit          FWD_MCLK     = 1'b1,
   localparam int unsigned RATIO_SEL_W = (RATIO_OPTS > 1) ? $clog2(RATIO_OPTS) : 1,
   localparam int unsigned BPF_SEL_W   = (BPF_OPTS > 1) ? $clog2(BPF_OPTS) : 1,
   localparam int unsigned CNT_W       = RATIO_LG_MIN + RATIO_OPTS - 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [RATIO_SEL_W-1:0] ratio_sel,
   input  logic [BPF_SEL_W-1:0]   frame_sel,
   output logic                   mclk_o,
   output logic                   bclk_o,
   output logic                   wclk_o,
   output logic                   cfg_err_o
);

   generate
      if (RATIO_OPTS < 1 || BPF_OPTS < 1) begin : g_bad_opts
         $error("i2s_mclk_divider: option counts must be at least one");
      end
      if (CNT_W > 24 || CNT_W >= (1 << LG_W)) begin : g_bad_width
         $error("i2s_mclk_divider: frame counter too wide");
      end
      if (RATIO_LG_MIN < 1) begin : g_bad_ratio
         $error("i2s_mclk_divider: smallest ratio must be at least two");
      end
   endgenerate

   clk_cfg_t         cfg_d, cfg_q;
   logic             ok_d, ok_q;
   logic             wrap;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             load;

   // selects are taken in reset, at a frame wrap, or while the current one is illegal
   assign load = rst | wrap | ~ok_q;

   i2s_cfg_reg #(
      .RATIO_LG_MIN (RATIO_LG_MIN),
      .RATIO_OPTS   (RATIO_OPTS),
      .BPF_LG_MIN   (BPF_LG_MIN),
      .BPF_OPTS     (BPF_OPTS),
      .RATIO_SEL_W  (RATIO_SEL_W),
      .BPF_SEL_W    (BPF_SEL_W)
   ) u_cfg (
      .clk       (clk),
      .load      (load),
      .ratio_sel (ratio_sel),
      .frame_sel (frame_sel),
      .cfg_d     (cfg_d),
      .ok_d      (ok_d),
      .cfg_q     (cfg_q),
      .ok_q      (ok_q)
   );

   i2s_frame_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .run   (ok_q),
      .rl    (cfg_q.rl),
      .cnt_q (cnt_q),
      .cnt_d (cnt_d),
      .wrap  (wrap)
   );

   i2s_edge_gen #(
      .CNT_W (CNT_W)
   ) u_edge (
      .clk    (clk),
      .rst    (rst),
      .cnt_d  (cnt_d),
      .cfg_d  (cfg_d),
      .ok_d   (ok_d),
      .bclk_q (bclk_o),
      .wclk_q (wclk_o),
      .err_q  (cfg_err_o)
   );

   generate
      if (FWD_MCLK) begin : g_fwd
         assign mclk_o = clk;
      end else begin : g_no_fwd
         assign mclk_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/i2s_mclk_divider_chk.sv
module i2s_mclk_divider_chk
   import i2s_clkdiv_pkg::*;
#(
   parameter int unsigned CNT_W = 9
) (
   input logic             clk,
   input logic             rst,
   input logic             bclk_o,
   input logic             wclk_o,
   input logic             cfg_err_o,
   input logic [CNT_W-1:0] cnt,
   input clk_cfg_t         cfg
);

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
      cfg_err_o |-> (!bclk_o && !wclk_o)); // R6

   AST_ERR_HOLD_START: assert property (@(posedge clk) disable iff (rst)
      cfg_err_o |-> (cnt == '0)); // R6

   AST_WCLK_ON_BFALL: assert property (@(posedge clk) disable iff (rst)
      (wclk_o != $past(wclk_o)) |-> $fell(bclk_o)); // R4

   AST_WFALL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
      $fell(wclk_o) |-> (cnt == '0)); // R2

   AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
      (cfg != $past(cfg)) |-> (cnt == '0)); // R5

endmodule

bind i2s_mclk_divider i2s_mclk_divider_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bclk_o    (bclk_o),
   .wclk_o    (wclk_o),
   .cfg_err_o (cfg_err_o),
   .cnt       (cnt_q),
   .cfg       (cfg_q)
);

// File: tb/i2s_mclk_divider_tb.sv
module i2s_mclk_divider_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] ratio_sel = 2'd3;
   logic [0:0] frame_sel = 1'b1;
   logic       mclk_o, bclk_o, wclk_o, cfg_err_o;

   int total = 0;
   int bad   = 0;

   i2s_mclk_divider u_dut (
      .clk       (clk),
      .rst       (rst),
      .ratio_sel (ratio_sel),
      .frame_sel (frame_sel),
      .mclk_o    (mclk_o),
      .bclk_o    (bclk_o),
      .wclk_o    (wclk_o),
      .cfg_err_o (cfg_err_o)
   );

   always #10 clk = ~clk;   // 50 MHz

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // behavioural reference, written from the requirements
   int m_cnt = 0, m_ratio = 512, m_bpf = 64;
   int m_b = 0, m_w = 0, m_e = 0;
   bit cmp_en = 0;

   function automatic int illegal(input int r, input int b);
      return (r < 2 * b) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_ratio = 64 << ratio_sel;
         m_bpf   = 32 << frame_sel;
         m_cnt   = 0;
         m_b     = 0;
         m_w     = 0;
         m_e     = illegal(m_ratio, m_bpf);
      end else if (illegal(m_ratio, m_bpf) != 0) begin
         m_ratio = 64 << ratio_sel;
         m_bpf   = 32 << frame_sel;
         m_cnt   = 0;
         m_b     = 0;
         m_w     = 0;
         m_e     = illegal(m_ratio, m_bpf);
      end else begin
         if (m_cnt == m_ratio - 1) begin
            m_cnt   = 0;
            m_ratio = 64 << ratio_sel;
            m_bpf   = 32 << frame_sel;
         end else begin
            m_cnt++;
         end
         m_e = illegal(m_ratio, m_bpf);
         if (m_e != 0) begin
            m_b = 0;
            m_w = 0;
         end else begin
            m_b = (m_cnt / (m_ratio / (2 * m_bpf))) % 2;
            m_w = (m_cnt >= m_ratio / 2) ? 1 : 0;
         end
      end
      cmp_en = 1;
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R3", "bclk vs model", int'(bclk_o), m_b);
         chk("R2", "wclk vs model", int'(wclk_o), m_w);
         chk("R6", "err vs model",  int'(cfg_err_o), m_e);
      end
   end

   // from one word-clock rise to the next: period, high samples, bit-clock rises
   task automatic measure(output int per, output int hi, output int rs);
      logic pw, pb;
      pw = wclk_o;
      forever begin
         @(negedge clk);
         if (wclk_o && !pw) break;
         pw = wclk_o;
      end
      per = 0; hi = 1; rs = 0;
      pw = 1'b1; pb = bclk_o;
      forever begin
         @(negedge clk);
         per++;
         if (wclk_o && !pw) break;
         if (wclk_o) hi++;
         if (bclk_o && !pb) rs++;
         pw = wclk_o;
         pb = bclk_o;
      end
   endtask

   task automatic check_cfg(input int sel, input int fsel);
      int per, hi, rs, r, b;
      r = 64 << sel;
      b = 32 << fsel;
      @(negedge clk);
      ratio_sel = 2'(sel);
      frame_sel = 1'(fsel);
      measure(per, hi, rs);   // frame that may still hold the old setting
      measure(per, hi, rs);
      chk("R1", "word clock period", per, r);
      chk("R2", "word clock high time", hi, r / 2);
      chk("R3", "bit clock rises per frame", rs, b);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int per, hi, rs, n;
      repeat (4) @(negedge clk);
      chk("R7", "bclk in reset", int'(bclk_o), 0);
      chk("R7", "wclk in reset", int'(wclk_o), 0);
      chk("R7", "err in reset", int'(cfg_err_o), 0);
      rst = 1'b0;

      // R8: forwarded master clock
      @(negedge clk);
      chk("R8", "mclk low phase", int'(mclk_o), 0);
      @(posedge clk); #1;
      chk("R8", "mclk high phase", int'(mclk_o), 1);

      measure(per, hi, rs);
      chk("R1", "period at 512", per, 512);
      chk("R2", "high time at 512", hi, 256);
      chk("R3", "bit rises at 512/64", rs, 64);

      // R5: change in mid-frame, right half of the current frame must stay 256 long
      measure(per, hi, rs);
      ratio_sel = 2'd0;
      frame_sel = 1'b0;
      n = 1;
      forever begin
         @(negedge clk);
         if (!wclk_o) break;
         n++;
      end
      chk("R5", "high time after mid-frame change", n, 256);
      measure(per, hi, rs);
      chk("R5", "new period after boundary", per, 64);
      chk("R3", "bit rises at 64/32", rs, 32);

      check_cfg(1, 1);
      check_cfg(2, 0);
      check_cfg(3, 0);

      // R6: illegal combination
      @(negedge clk);
      ratio_sel = 2'd0;
      frame_sel = 1'b1;
      n = 0;
      while (!cfg_err_o && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk("R6", "error flag raised", int'(cfg_err_o), 1);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk("R6", "bclk held low", int'(bclk_o), 0);
         chk("R6", "wclk held low", int'(wclk_o), 0);
      end
      frame_sel = 1'b0;
      @(negedge clk);
      chk("R6", "error flag cleared", int'(cfg_err_o), 0);
      measure(per, hi, rs);
      chk("R6", "period after recovery", per, 64);

      // R7: reset in the middle of a run
      repeat (10) @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7", "bclk during mid-run reset", int'(bclk_o), 0);
      chk("R7", "wclk during mid-run reset", int'(wclk_o), 0);
      rst = 1'b0;
      @(negedge clk);
      // 64 ratio, 32 bits: one-cycle half period, count 1 after release
      chk("R7", "bclk first cycle after reset", int'(bclk_o), 1);
      chk("R7", "wclk first cycle after reset", int'(wclk_o), 0);
      repeat (100) @(negedge clk);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule